// File: doc/BRIEF.md
# Funnel Shifter with Second-Operand Fill

This combinational block moves a destination word left or right by a count. The bit positions that open up are filled from a second word, called the fill word, instead of with zeros. In left mode the fill bits come from the top of the fill word. In right mode they come from the bottom of it. The result is one operand wide, and the fill word itself is never altered. Only the destination is replaced. The operand width is fixed by a parameter to 16 or 32 bits.

The count port is wider than needed, and only the count reduced modulo the operand width takes effect. Besides the result, the block produces two flag signals. The first is a carry, which is the last destination bit pushed out. The second is a flag-write enable, which tells the surrounding datapath whether the flags should be updated. A zero effective count leaves everything as it was.

Top module: `funnel_shifter`

## Requirements
- R1: With `dir_i` = 1 (left) and effective count k > 0, `res_o` equals the destination shifted up by k, with its low k bits taken from the top k bits of `src_i`.
- R2: With `dir_i` = 0 (right) and k > 0, `res_o` equals the destination shifted down by k, with its top k bits taken from the low k bits of `src_i`.
- R3: The effective count k is `cnt_i` modulo W, so counts of W and above act the same as their remainder.
- R4: When k = 0, `res_o` equals `dst_i`, and both `carry_o` and `flag_we_o` are 0, whatever the direction.
- R5: In left mode with k > 0, `carry_o` equals `dst_i` bit W−k.
- R6: In right mode with k > 0, `carry_o` equals `dst_i` bit k−1.
- R7: `flag_we_o` is 1 exactly when k is nonzero.
- R8: At W = 16, the following two cases hold. Right mode with destination 0x5500, fill 0xFFFF and count 4 gives 0xF550. Left mode with destination 0xFFFF, fill 0xF550 and count 8 gives 0xFFF5.
- R9: At W = 32 the same rules hold, with the count reduced modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | W | Destination word to be shifted |
| src_i | input | W | Fill word supplying the vacated bits |
| cnt_i | input | CNT_W | Raw shift count, reduced modulo W |
| dir_i | input | 1 | 1 selects left, 0 selects right |
| res_o | output | W | Shifted result |
| carry_o | output | 1 | Last destination bit shifted out |
| flag_we_o | output | 1 | High when the effective count is nonzero |

## Verification
The block holds no state. An error in the count reduction or in the funnel selection therefore shows up on `res_o` and `carry_o` in the same cycle the inputs are applied. A count reduced the wrong way shows up first as a wrong result at counts of W and above. A fill taken from the wrong end of the fill word shows up in the lowest or highest result bits. An off-by-one in the carry index appears as soon as the destination bits next to the boundary differ from each other. For that reason the sweeps use irregular data words and every count value.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  typedef enum logic {
    FSH_RIGHT = 1'b0,
    FSH_LEFT  = 1'b1
  } fsh_dir_e;

  function automatic bit fsh_width_pow2(int w);
    return (w == 16) || (w == 32);
  endfunction
endpackage

// File: rtl/funnel_count_reduce.sv
module funnel_count_reduce #(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  localparam int KW   = $clog2(W)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [KW-1:0]    k_o,
  output logic             nz_o
);
  generate
    if (fsh_pkg::fsh_width_pow2(W)) begin : g_mask
      // power-of-two width: modulo is a plain truncation
      assign k_o = cnt_i[KW-1:0];
    end else begin : g_mod
      logic [CNT_W-1:0] rem;
      assign rem = cnt_i % CNT_W'(W);
      assign k_o = rem[KW-1:0];
    end
  endgenerate

  assign nz_o = |k_o;
endmodule

// File: rtl/funnel_core.sv
module funnel_core #(
  parameter int W   = 16,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]        dst_i,
  input  logic [W-1:0]        src_i,
  input  logic [KW-1:0]       k_i,
  input  fsh_pkg::fsh_dir_e   dir_i,
  output logic [W-1:0]        res_o
);
  logic [2*W-1:0] cat_l, cat_r, sh_l, sh_r;

  always_comb begin
    cat_l = {dst_i, src_i};
    cat_r = {src_i, dst_i};
    sh_l  = cat_l << k_i;
    sh_r  = cat_r >> k_i;
    if (dir_i == fsh_pkg::FSH_LEFT) res_o = sh_l[2*W-1:W];
    else                            res_o = sh_r[W-1:0];
  end
endmodule

// File: rtl/funnel_carry.sv
module funnel_carry #(
  parameter int W   = 16,
  localparam int KW = $clog2(W)
) (
  input  logic [W-1:0]        dst_i,
  input  logic [KW-1:0]       k_i,
  input  logic                nz_i,
  input  fsh_pkg::fsh_dir_e   dir_i,
  output logic                carry_o
);
  logic [KW:0]   lidx_w;
  logic [KW-1:0] lidx, ridx;

  always_comb begin
    lidx_w = (KW+1)'(W) - {1'b0, k_i};
    lidx   = lidx_w[KW-1:0];
    ridx   = k_i - KW'(1);
    if (!nz_i)                           carry_o = 1'b0;
    else if (dir_i == fsh_pkg::FSH_LEFT) carry_o = dst_i[lidx];
    else                                 carry_o = dst_i[ridx];
  end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     dst_i,
  input  logic [W-1:0]     src_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o,
  output logic             flag_we_o
);
  localparam int KW = $clog2(W);

  fsh_pkg::fsh_dir_e dir;
  logic [KW-1:0]     k;
  logic              nz;
  logic [W-1:0]      shifted;

  assign dir = fsh_pkg::fsh_dir_e'(dir_i);

  funnel_count_reduce #(.W(W), .CNT_W(CNT_W)) u_cnt (
    .cnt_i (cnt_i),
    .k_o   (k),
    .nz_o  (nz)
  );

  funnel_core #(.W(W)) u_core (
    .dst_i (dst_i),
    .src_i (src_i),
    .k_i   (k),
    .dir_i (dir),
    .res_o (shifted)
  );

  funnel_carry #(.W(W)) u_carry (
    .dst_i   (dst_i),
    .k_i     (k),
    .nz_i    (nz),
    .dir_i   (dir),
    .carry_o (carry_o)
  );

  // a zero count passes the destination through untouched
  assign res_o     = nz ? shifted : dst_i;
  assign flag_we_o = nz;
endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic [W-1:0]     dst_i,
  input logic [W-1:0]     src_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             dir_i,
  input logic [W-1:0]     res_o,
  input logic             carry_o,
  input logic             flag_we_o
);
  int k;

  always_comb begin
    k = int'(cnt_i) % W;
    if (k == 0) begin
      AST_ZERO_PASS: assert (res_o == dst_i && !carry_o && !flag_we_o); // R4
    end else begin
      AST_WE_SET: assert (flag_we_o); // R7
      if (dir_i) begin
        AST_CARRY_LEFT: assert (carry_o == dst_i[W-k]); // R5
        AST_FILL_LEFT: assert (res_o[0] == src_i[W-k]); // R1
      end else begin
        AST_CARRY_RIGHT: assert (carry_o == dst_i[k-1]); // R6
        AST_FILL_RIGHT: assert (res_o[W-1] == src_i[k-1]); // R2
      end
    end
  end
endmodule

bind funnel_shifter funnel_shifter_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .dst_i     (dst_i),
  .src_i     (src_i),
  .cnt_i     (cnt_i),
  .dir_i     (dir_i),
  .res_o     (res_o),
  .carry_o   (carry_o),
  .flag_we_o (flag_we_o)
);

// File: tb/tb_funnel_shifter.sv
module tb_funnel_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic clk;
  int   checks, fails, cyc;

  logic [15:0] d16, s16, r16;
  logic [7:0]  c16;
  logic        dir16, cy16, we16;
  logic [31:0] d32, s32, r32;
  logic [7:0]  c32;
  logic        dir32, cy32, we32;

  funnel_shifter #(.W(16), .CNT_W(8)) dut (
    .dst_i(d16), .src_i(s16), .cnt_i(c16), .dir_i(dir16),
    .res_o(r16), .carry_o(cy16), .flag_we_o(we16));

  funnel_shifter #(.W(32), .CNT_W(8)) dut_w32 (
    .dst_i(d32), .src_i(s32), .cnt_i(c32), .dir_i(dir32),
    .res_o(r32), .carry_o(cy32), .flag_we_o(we32));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // arithmetic model: concatenate, shift the double word, keep one half
  function automatic void model(input int w, input logic [31:0] d, input logic [31:0] s,
                                input int c, input bit left,
                                output logic [31:0] r, output bit cy, output bit we);
    logic [63:0] mask, cat;
    int k;
    k    = c % w;
    mask = (64'd1 << w) - 64'd1;
    we   = (k != 0);
    if (left) begin
      cat = ({32'd0, d} << w) | {32'd0, s};
      r   = 32'(((cat << k) >> w) & mask);
      cy  = (k != 0) ? cat[2*w-k] : 1'b0;
    end else begin
      cat = ({32'd0, s} << w) | {32'd0, d};
      r   = 32'((cat >> k) & mask);
      cy  = (k != 0) ? d[k-1] : 1'b0;
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run16(input logic [15:0] d, input logic [15:0] s, input int c, input bit left);
    logic [31:0] er;
    bit ecy, ewe;
    int k;
    @(posedge clk);
    d16 = d; s16 = s; c16 = 8'(c); dir16 = left;
    @(negedge clk);
    model(16, {16'd0, d}, {16'd0, s}, c, left, er, ecy, ewe);
    k = c % 16;
    if (k == 0) begin
      chk("R4 result", {16'd0, r16}, er);
      chk("R4 carry", {31'd0, cy16}, {31'd0, ecy});
    end else begin
      if (c >= 16) chk("R3 result", {16'd0, r16}, er);
      else if (left) chk("R1 result", {16'd0, r16}, er);
      else chk("R2 result", {16'd0, r16}, er);
      if (left) chk("R5 carry", {31'd0, cy16}, {31'd0, ecy});
      else      chk("R6 carry", {31'd0, cy16}, {31'd0, ecy});
    end
    chk("R7 flag_we", {31'd0, we16}, {31'd0, ewe});
  endtask

  task automatic run32(input logic [31:0] d, input logic [31:0] s, input int c, input bit left);
    logic [31:0] er;
    bit ecy, ewe;
    @(posedge clk);
    d32 = d; s32 = s; c32 = 8'(c); dir32 = left;
    @(negedge clk);
    model(32, d, s, c, left, er, ecy, ewe);
    chk("R9 result", r32, er);
    chk("R9 carry", {31'd0, cy32}, {31'd0, ecy});
    chk("R9 flag_we", {31'd0, we32}, {31'd0, ewe});
  endtask

  logic [31:0] rng;
  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    checks = 0; fails = 0; cyc = 0;
    d16 = '0; s16 = '0; c16 = '0; dir16 = 1'b0;
    d32 = '0; s32 = '0; c32 = '0; dir32 = 1'b0;
    rng = 32'h1badf00d;

    // idle inputs: zero result, no carry, no flag write
    @(negedge clk);
    chk("R4 idle result", {16'd0, r16}, 32'd0);
    chk("R7 idle flag_we", {31'd0, we16}, 32'd0);

    // fixed vectors
    run16(16'h5500, 16'hFFFF, 4, 1'b0);
    chk("R8 right vector", {16'd0, r16}, 32'h0000F550);
    chk("R8 right carry", {31'd0, cy16}, 32'd0);
    run16(16'hFFFF, 16'hF550, 8, 1'b1);
    chk("R8 left vector", {16'd0, r16}, 32'h0000FFF5);
    chk("R8 left carry", {31'd0, cy16}, 32'd1);

    // corner patterns at every count, both directions
    for (int p = 0; p < 4; p++) begin
      logic [15:0] dp, sp;
      case (p)
        0: begin dp = 16'h8001; sp = 16'h0000; end
        1: begin dp = 16'h0000; sp = 16'hFFFF; end
        2: begin dp = 16'hAAAA; sp = 16'h5555; end
        default: begin dp = 16'h0001; sp = 16'h8000; end
      endcase
      for (int c = 0; c < 256; c++) begin
        run16(dp, sp, c, 1'b1);
        run16(dp, sp, c, 1'b0);
      end
    end

    // irregular data at every count, both directions
    for (int p = 0; p < 20; p++) begin
      logic [15:0] dp, sp;
      rng = nxt(rng); dp = rng[15:0]; sp = rng[31:16];
      for (int c = 0; c < 256; c++) begin
        run16(dp, sp, c, 1'b1);
        run16(dp, sp, c, 1'b0);
      end
    end

    // wider instance
    for (int p = 0; p < 8; p++) begin
      logic [31:0] dp, sp;
      rng = nxt(rng); dp = rng;
      rng = nxt(rng); sp = rng;
      for (int c = 0; c < 70; c++) begin
        run32(dp, sp, c, 1'b1);
        run32(dp, sp, c, 1'b0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule